// File: doc/BRIEF.md
# Instruction-Byte Serial Register Port

This block is a slave serial port. It gives an external host read and write access to a small bank of 24-bit registers. There are five registers: a conversion-result register, a control register, an offset calibration register, and two full-scale calibration registers (positive and negative).

Every transfer opens with an 8-bit command byte. The command byte chooses four things:

- the direction of the transfer;
- how many data bytes follow (one to four);
- which register is targeted;
- the byte inside that register where the transfer starts.

The host drives a chip-select line, a serial clock and a shared data line. The block also has a dedicated data-out line. A mode input decides whether read data returns on the dedicated line or on the shared line.

The host lines are sampled by the block's own system clock. Edges of the serial clock are found by comparing its level with a one-cycle-old copy. Any synchronizer for an asynchronous host belongs outside the block. The shared data line is split into input, output and output-enable signals, so the pad itself also sits outside.

The result register is loaded from a parallel port with a load strobe. The three writable registers are visible as parallel outputs for the logic around the block, as are both full-scale registers.

Top module: `rb_serial_port`

## Requirements
- R1: Command bit 7 sets the direction: 1 means the data bytes are written into the block, and 0 means they are read out of it.
- R2: Command bits 6:5 hold the number of data bytes minus one (00 = 1 byte, 11 = 4 bytes).
- R3: Command bits 3:2 pick the register: 00 = result, 01 = control, 10 = offset, 11 = full-scale. Bits 1:0 give the first byte index. Byte k of a register is bits 8k+7:8k. After each data byte the index goes up by one, and index 2 is followed by index 0. A read at index 3 returns 8'h00, and the read then continues at index 0.
- R4: When bits 3:2 are 11, command bit 4 selects the positive (0) or negative (1) full-scale register. For every other register, bit 4 has no effect.
- R5: The data phase begins on the 8th rising serial-clock edge after chip select falls. After the last data byte, the next 8 rising edges form a fresh command byte, provided chip select stays low.
- R6: Input bits are taken from the shared data line at rising serial-clock edges, most significant bit first. A written byte is stored into its register at the 8th rising edge of that byte.
- R7: Read data changes only after falling serial-clock edges, most significant bit first, so the host can capture each bit on the next rising edge.
- R8: Read data is driven during the read data phase and at no other time:
  - with mode_2w = 0, on sdo, with sdo_oe high;
  - with mode_2w = 1, on sdio_o, with sdio_oe high.
  The two enables are never high together.
- R9: The result register is read-only and takes dat_in when dat_load is high. A write aimed at the result register, or starting at byte index 3, changes no register.
- R10: While chip select is high, both output enables are low and the port waits for a command byte. A write byte that is cut short by chip select rising is discarded.
- R11: After reset, all five registers read as zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the host lines |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side (2-wire reads) |
| sdio_oe | output | 1 | Output enable for the shared data line |
| sdo | output | 1 | Dedicated read data line (3-wire reads) |
| sdo_oe | output | 1 | Output enable for the dedicated line |
| mode_2w | input | 1 | 1: reads return on the shared line; 0: on the dedicated line |
| dat_load | input | 1 | Load strobe for the result register |
| dat_in | input | REG_W | Parallel value for the result register |
| ctrl_reg | output | REG_W | Control register contents |
| offs_reg | output | REG_W | Offset calibration register contents |
| pfs_reg | output | REG_W | Positive full-scale register contents |
| nfs_reg | output | REG_W | Negative full-scale register contents |

## Verification
The assertions assume that:

- the serial clock rests low while chip select is high;
- each serial-clock level lasts at least one system-clock cycle;
- mode_2w and the shared data input stay steady from one falling serial edge until after the next rising edge.

The stimulus keeps to these conditions:

- Every serial-clock level is held for three system cycles.
- Inputs change only on the falling system-clock edge.
- The mode is set only while chip select is high.

The sweep covers every register, every starting index, every length and both read modes. It then aborts transfers partway through a byte, and sends two commands back to back under one chip select.

// File: rtl/rb_serial_pkg.sv
package rb_serial_pkg;

  localparam int CMD_W = 8;

  // Field order follows the bit positions of the command byte.
  typedef struct packed {
    logic       wr;     // bit 7
    logic [1:0] len;    // bits 6:5
    logic       neg;    // bit 4
    logic [1:0] rsel;   // bits 3:2
    logic [1:0] start;  // bits 1:0
  } cmd_t;

  typedef enum logic [2:0] {
    TGT_DATA = 3'd0,
    TGT_CTRL = 3'd1,
    TGT_OFFS = 3'd2,
    TGT_PFS  = 3'd3,
    TGT_NFS  = 3'd4
  } tgt_e;

  function automatic tgt_e decode_tgt(cmd_t c);
    case (c.rsel)
      2'd0:    return TGT_DATA;
      2'd1:    return TGT_CTRL;
      2'd2:    return TGT_OFFS;
      default: return c.neg ? TGT_NFS : TGT_PFS;
    endcase
  endfunction

  function automatic logic [1:0] next_idx(logic [1:0] i, int nbyte);
    return (int'(i) >= nbyte - 1) ? 2'd0 : i + 2'd1;
  endfunction

  // Byte slots above the register width read as zero.
  function automatic logic [7:0] pick_byte(logic [31:0] r, logic [1:0] i);
    return r[{i, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/rb_frame_ctrl.sv
module rb_frame_ctrl
  import rb_serial_pkg::*;
#(
  parameter int NBYTE = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       sdi,
  output logic       ev_fall,
  output logic       ev_instr_done,
  output logic       in_data,
  output logic       rd_act,
  output logic       ld_tx,
  output logic       wr_commit,
  output logic [7:0] wr_byte,
  output cmd_t       cmd,
  output logic [1:0] idx
);

  logic       sck_q;
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic [1:0] remain;
  logic       ev_rise;
  logic       byte_done;
  logic       wr_ok;

  assign ev_rise       = !cs_n && sck && !sck_q;
  assign ev_fall       = !cs_n && !sck && sck_q;
  assign byte_done     = ev_rise && (bitcnt == 3'd7);
  assign wr_byte       = {rx_sh, sdi};
  assign ev_instr_done = byte_done && !in_data;
  assign wr_ok         = cmd.wr && (decode_tgt(cmd) != TGT_DATA)
                         && (int'(cmd.start) < NBYTE);
  assign wr_commit     = byte_done && in_data && wr_ok;
  assign rd_act        = in_data && !cmd.wr;
  assign ld_tx         = ev_fall && rd_act && (bitcnt == 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      bitcnt  <= '0;
      rx_sh   <= '0;
      remain  <= '0;
      in_data <= 1'b0;
      cmd     <= '0;
      idx     <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        bitcnt  <= '0;
        in_data <= 1'b0;
      end else if (ev_rise) begin
        bitcnt <= bitcnt + 3'd1;
        rx_sh  <= {rx_sh[5:0], sdi};
        if (byte_done) begin
          if (!in_data) begin
            cmd     <= cmd_t'(wr_byte);
            in_data <= 1'b1;
            idx     <= wr_byte[1:0];
            remain  <= wr_byte[6:5];
          end else if (remain == 2'd0) begin
            in_data <= 1'b0;
          end else begin
            remain <= remain - 2'd1;
            idx    <= next_idx(idx, NBYTE);
          end
        end
      end
    end
  end

endmodule

// File: rtl/rb_reg_bank.sv
module rb_reg_bank
  import rb_serial_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  tgt_e             tgt,
  input  logic [1:0]       idx,
  input  logic [7:0]       wr_byte,
  input  logic             dat_load,
  input  logic [REG_W-1:0] dat_in,
  output logic [REG_W-1:0] dat_q,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] offs_q,
  output logic [REG_W-1:0] pfs_q,
  output logic [REG_W-1:0] nfs_q,
  output logic [7:0]       rd_byte
);

  localparam int NBYTE = REG_W / 8;
  localparam int NWR   = 4;

  logic [REG_W-1:0] wq [NWR];
  logic [REG_W-1:0] sel;

  always_ff @(posedge clk) begin
    if (!rst_n)        dat_q <= '0;
    else if (dat_load) dat_q <= dat_in;
  end

  for (genvar g = 0; g < NWR; g++) begin : g_reg
    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          wq[g][b*8 +: 8] <= '0;
        else if (wr_en && tgt == tgt_e'(3'(g + 1)) && idx == 2'(b))
          wq[g][b*8 +: 8] <= wr_byte;
      end
    end
  end

  assign ctrl_q = wq[0];
  assign offs_q = wq[1];
  assign pfs_q  = wq[2];
  assign nfs_q  = wq[3];

  always_comb begin
    case (tgt)
      TGT_CTRL: sel = wq[0];
      TGT_OFFS: sel = wq[1];
      TGT_PFS:  sel = wq[2];
      TGT_NFS:  sel = wq[3];
      default:  sel = dat_q;
    endcase
  end

  assign rd_byte = pick_byte(32'(sel), idx);

endmodule

// File: rtl/rb_tx_out.sv
module rb_tx_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ev_fall,
  input  logic       ld_tx,
  input  logic       rd_act,
  input  logic       mode_2w,
  input  logic [7:0] rd_byte,
  output logic       tx_bit,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       sdio_o,
  output logic       sdio_oe
);

  logic [6:0] tx_sh;
  logic       drive;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      tx_bit <= 1'b0;
      drive  <= 1'b0;
    end else if (cs_n) begin
      tx_bit <= 1'b0;
      drive  <= 1'b0;
    end else if (ld_tx) begin
      tx_bit <= rd_byte[7];
      tx_sh  <= rd_byte[6:0];
      drive  <= 1'b1;
    end else if (ev_fall && rd_act) begin
      tx_bit <= tx_sh[6];
      tx_sh  <= {tx_sh[5:0], 1'b0};
    end else if (!rd_act) begin
      drive <= 1'b0;
    end
  end

  assign sdo_oe  = drive && !mode_2w;
  assign sdio_oe = drive && mode_2w;
  assign sdo     = sdo_oe && tx_bit;
  assign sdio_o  = sdio_oe && tx_bit;

endmodule

// File: rtl/rb_serial_port.sv
module rb_serial_port
  import rb_serial_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdio_i,
  output logic             sdio_o,
  output logic             sdio_oe,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic             mode_2w,
  input  logic             dat_load,
  input  logic [REG_W-1:0] dat_in,
  output logic [REG_W-1:0] ctrl_reg,
  output logic [REG_W-1:0] offs_reg,
  output logic [REG_W-1:0] pfs_reg,
  output logic [REG_W-1:0] nfs_reg
);

  localparam int NBYTE = REG_W / 8;

  // Internal events, named so the bound checker can observe them.
  logic             ev_fall;
  logic             ev_instr_done;
  logic             in_data;
  logic             rd_act;
  logic             ld_tx;
  logic             wr_commit;
  logic             tx_bit;
  logic [7:0]       wr_byte;
  logic [7:0]       rd_byte;
  logic [1:0]       idx;
  logic [REG_W-1:0] dat_q;
  cmd_t             cmd;
  tgt_e             tgt;

  assign tgt = decode_tgt(cmd);

  rb_frame_ctrl #(.NBYTE(NBYTE)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdio_i),
    .ev_fall(ev_fall), .ev_instr_done(ev_instr_done), .in_data(in_data),
    .rd_act(rd_act), .ld_tx(ld_tx), .wr_commit(wr_commit),
    .wr_byte(wr_byte), .cmd(cmd), .idx(idx)
  );

  rb_reg_bank #(.REG_W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_commit), .tgt(tgt), .idx(idx),
    .wr_byte(wr_byte), .dat_load(dat_load), .dat_in(dat_in),
    .dat_q(dat_q), .ctrl_q(ctrl_reg), .offs_q(offs_reg),
    .pfs_q(pfs_reg), .nfs_q(nfs_reg), .rd_byte(rd_byte)
  );

  rb_tx_out u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ev_fall(ev_fall),
    .ld_tx(ld_tx), .rd_act(rd_act), .mode_2w(mode_2w), .rd_byte(rd_byte),
    .tx_bit(tx_bit), .sdo(sdo), .sdo_oe(sdo_oe),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe)
  );

endmodule

// File: rtl/rb_serial_port_chk.sv
module rb_serial_port_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         sdo_oe,
  input logic         sdio_oe,
  input logic         ev_fall,
  input logic         tx_bit,
  input logic         ev_instr_done,
  input logic         in_data,
  input logic         wr_commit,
  input logic         dat_load,
  input logic [W-1:0] ctrl_reg,
  input logic [W-1:0] dat_q
);

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));                                          // R8

  AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!sdo_oe && !sdio_oe));                                // R10

  AST_TX_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !ev_fall) |=> $stable(tx_bit));                       // R7

  AST_CMD_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_instr_done |=> in_data);                                     // R5

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_reg));                              // R6

  AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !cs_n);                                           // R10

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_load |=> $stable(dat_q));                                  // R9

endmodule

bind rb_serial_port rb_serial_port_chk #(.W(REG_W)) u_chk (.*);

// File: tb/sim_rb_serial_port.sv
module sim_rb_serial_port;

  localparam int CLK_P = 10;
  localparam int HP    = 3;
  localparam int W     = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1;
  logic         sck = 1'b0;
  logic         sdio_i = 1'b0;
  logic         mode_2w = 1'b0;
  logic         dat_load = 1'b0;
  logic [W-1:0] dat_in = '0;
  logic         sdio_o, sdio_oe, sdo, sdo_oe;
  logic [W-1:0] ctrl_reg, offs_reg, pfs_reg, nfs_reg;

  int checks = 0;
  int bad = 0;
  bit done = 0;
  logic [W-1:0] mdl [5];  // 0 result, 1 ctrl, 2 offs, 3 pos fs, 4 neg fs

  always #(CLK_P/2) clk = ~clk;

  rb_serial_port #(.REG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .mode_2w(mode_2w), .dat_load(dat_load), .dat_in(dat_in),
    .ctrl_reg(ctrl_reg), .offs_reg(offs_reg), .pfs_reg(pfs_reg),
    .nfs_reg(nfs_reg)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_regs(string req);
    chk(req, {8'h0, ctrl_reg}, {8'h0, mdl[1]});
    chk(req, {8'h0, offs_reg}, {8'h0, mdl[2]});
    chk(req, {8'h0, pfs_reg},  {8'h0, mdl[3]});
    chk(req, {8'h0, nfs_reg},  {8'h0, mdl[4]});
  endtask

  task automatic put_bit(logic b);
    @(negedge clk); sck = 1'b0; sdio_i = b;
    repeat (HP) @(negedge clk);
    sck = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic put_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  // Returns the sampled bit and whether only the expected pin was enabled.
  task automatic get_bit(output logic v, output logic oe_ok);
    @(negedge clk); sck = 1'b0;
    repeat (HP) @(negedge clk);
    v = mode_2w ? sdio_o : sdo;
    oe_ok = mode_2w ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe);
    sck = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk); sck = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] mk_cmd(bit wr, int c, int t, int s);
    logic [1:0] rsel;
    logic       neg;
    rsel = (t >= 3) ? 2'd3 : 2'(t);
    neg  = (t == 4) ? 1'b1 : ((t == 3) ? 1'b0 : 1'(c));  // R4 bit 4 don't-care
    return {wr, 2'(c), neg, rsel, 2'(s)};
  endfunction

  // Index visited by data byte k, per R3.
  function automatic int seq_idx(int s, int k);
    if (s == 3) return (k == 0) ? 3 : (k - 1) % 3;
    return (s + k) % 3;
  endfunction

  task automatic do_write(int t, int s, int c);
    logic [7:0] b;
    cs_low();
    put_byte(mk_cmd(1'b1, c, t, s));
    for (int k = 0; k <= c; k++) begin
      b = 8'((t * 53 + s * 17 + c * 29 + k * 71 + 5) % 256);
      put_byte(b);
      if (t != 0 && s != 3)
        mdl[t] = (mdl[t] & ~(24'hFF << (8 * seq_idx(s, k))))
                 | (W'(b) << (8 * seq_idx(s, k)));
    end
    cs_high();
  endtask

  task automatic do_read(int t, int s, int c, string req);
    logic [7:0] got, exp;
    logic       v, ok;
    logic       all_ok;
    cs_low();
    put_byte(mk_cmd(1'b0, c, t, s));
    all_ok = 1'b1;
    for (int k = 0; k <= c; k++) begin
      for (int i = 7; i >= 0; i--) begin
        get_bit(v, ok);
        got[i] = v;
        all_ok = all_ok && ok;
      end
      exp = 8'((mdl[t] >> (8 * seq_idx(s, k))) & 24'hFF);
      chk(req, {24'h0, got}, {24'h0, exp});
    end
    chk("R8 pin select", {31'h0, all_ok}, 32'h1);
    repeat (2) @(negedge clk);
    chk("R8 off after data", {30'h0, sdo_oe, sdio_oe}, 32'h0);
    cs_high();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    chk_regs("R11 reset regs");
    chk("R11 reset oe", {30'h0, sdo_oe, sdio_oe}, 32'h0);
    do_read(0, 0, 2, "R11 result zero");

    // R1 R2 R3 R4 R6: write sweep over registers, start index, length
    for (int t = 1; t <= 4; t++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++) begin
          do_write(t, s, c);
          chk_regs("R6 write sweep");
        end

    // R9 result register loads from parallel port
    @(negedge clk); dat_in = 24'hA53C96; dat_load = 1'b1;
    @(negedge clk); dat_load = 1'b0;
    mdl[0] = 24'hA53C96;

    // R9 write to result register is ignored
    do_write(0, 1, 2);
    chk_regs("R9 result write no effect");
    do_read(0, 0, 2, "R9 result unchanged");

    // R3 R7 R8 read sweep, both modes
    for (int t = 0; t <= 4; t++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++) begin
          @(negedge clk); mode_2w = 1'((s + c) % 2);
          do_read(t, s, c, "R7 read sweep");
        end

    // R10 abort mid write byte
    mode_2w = 1'b0;
    cs_low();
    put_byte(mk_cmd(1'b1, 0, 1, 0));
    for (int i = 0; i < 5; i++) put_bit(1'b1);
    cs_high();
    chk_regs("R10 partial write discarded");

    // R10 abort mid read: outputs release
    cs_low();
    put_byte(mk_cmd(1'b0, 1, 2, 0));
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    @(negedge clk); sck = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 driving before abort", {31'h0, sdo_oe}, 32'h1);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 oe after abort", {30'h0, sdo_oe, sdio_oe}, 32'h0);
    do_read(2, 0, 2, "R10 recovery read");

    // R5 two commands under one chip select
    cs_low();
    put_byte(mk_cmd(1'b1, 0, 2, 0));
    put_byte(8'h3C);
    mdl[2][7:0] = 8'h3C;
    put_byte(mk_cmd(1'b1, 0, 4, 2));
    put_byte(8'hC3);
    mdl[4][23:16] = 8'hC3;
    cs_high();
    chk_regs("R5 back to back commands");

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule